// File: doc/BRIEF.md
# Cascadable Four-Channel Reload Timer Bank

This block holds four 16-bit up-counters behind a small 16-bit register port. Each channel has two registers: a counter register and a control register. A channel counts either system clocks divided by a selectable prescaler, or the overflows of the channel numbered one below it (chained mode). When a channel counts past 0xFFFF, it does not stop at zero. It takes its programmed reload value instead, and it can raise its own interrupt line.

The overflow pulses of channels 0 and 1 leave the block on their own outputs, for an external audio or DMA service block. Interrupt line n is intended for system interrupt index n+8. A chained channel can overflow in the same clock cycle as the channel below it, so one overflow of channel 0 may step channels 1, 2 and 3 in a single cycle.

Address map: address bits [2:1] select the channel and bit 0 selects the register (0 for the counter, 1 for control). Control bit fields: bits [1:0] hold the prescale code, bit 2 the chained mode, bit 6 the interrupt enable and bit 7 the channel enable. The remaining control bits are stored and read back unchanged.

Top module: `tmr_bank`

## Requirements
- R1: After a synchronous reset, every counter, reload value and control word is 0, `rdata` is 0, and `irq` and `ovf_pulse` are low.
- R2: A write to a counter address (address bit 0 = 0) loads both the live count and the reload value. `rdata` returns the addressed register one cycle after the address is presented, and a counter address returns the live count.
- R3: A write to a control address (address bit 0 = 1) stores all 16 bits, and reading that address returns them unchanged.
- R4: A channel that is enabled (bit 7 = 1) and not chained (bit 2 = 0) counts once every 1, 64, 256 or 1024 of its enabled cycles, for prescale codes 0, 1, 2 and 3 respectively.
- R5: Each channel's prescaler keeps its residue. A free 10-bit cycle count advances only on enabled, unchained cycles. It is never cleared by disabling the channel or by changing the code, and a count occurs when the low 0, 6, 8 or 10 bits of that cycle count are all ones.
- R6: A count from 0xFFFF is an overflow, and the counter takes the reload value rather than 0.
- R7: On an overflow with interrupt enable (bit 6) set, `irq[n]` is high for exactly the next cycle. Without bit 6 set, the overflow raises no interrupt.
- R8: `ovf_pulse[n]` for channels 0 and 1 is high for the cycle after each overflow of that channel, regardless of bit 6.
- R9: An enabled chained channel n>0 counts exactly once in each cycle in which channel n-1 overflows, and otherwise holds. This chaining ripples through several channels in one cycle.
- R10: Channel 0 in chained mode never counts; its value holds.
- R11: A disabled channel holds its count.
- R12: A counter write in the same cycle as a count or an overflow wins: the written value is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| we | input | 1 | Write strobe for the addressed register |
| addr | input | 3 | {channel[1:0], register select} |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data of the addressed register |
| irq | output | 4 | Per-channel interrupt pulses |
| ovf_pulse | output | 2 | Overflow pulses of channels 0 and 1 |

## Verification
The bench builds the block with its default parameters: four channels, 16-bit counters and two exported pulse lines. With these, all three chaining links and both pulse outputs are exercised. Counters are preloaded close to 0xFFFF, so overflows, reloads and same-cycle ripples through all four channels occur within a few cycles. Prescale windows of up to 1024 cycles stay short enough to cover the residue kept across disable periods and code changes, together with a long random phase of register writes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // prescaler cycle-count width (largest divisor is 1024)
  localparam int PRE_W    = 10;
  localparam int CTL_CASC = 2;
  localparam int CTL_IE   = 6;
  localparam int CTL_EN   = 7;

  // low-bit mask of the cycle count that must be all ones for a count
  function automatic logic [PRE_W-1:0] div_mask(input logic [1:0] code);
    int sh;
    sh = (code == 2'd0) ? 0 : 4 + 2 * int'(code);
    return PRE_W'((1 << sh) - 1);
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] code,
  output logic       tick
);
  logic [PRE_W-1:0] acc_q;
  logic [PRE_W-1:0] mask;

  assign mask = div_mask(code);
  assign tick = run && ((acc_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else if (run) acc_q <= acc_q + 1'b1;
  end

  // R5: residue is kept while the channel is not running
  a_r5_residue_kept: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(acc_q));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_we,
  input  logic             ctl_we,
  input  logic [CNT_W-1:0] wdata,
  input  logic             step,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] ctl,
  output logic             ovf,
  output logic             irq
);
  logic [CNT_W-1:0] cnt_q, rld_q, ctl_q;
  logic             irq_q;

  assign ovf = step && (cnt_q == '1);
  assign cnt = cnt_q;
  assign ctl = ctl_q;
  assign irq = irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rld_q <= '0;
      ctl_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (cnt_we) begin
        cnt_q <= wdata;
        rld_q <= wdata;
      end else if (ovf) begin
        cnt_q <= rld_q;
      end else if (step) begin
        cnt_q <= cnt_q + 1'b1;
      end
      if (ctl_we) ctl_q <= wdata;
      irq_q <= ovf && ctl_q[CTL_IE];
    end
  end

  // R6: overflow loads the reload value
  a_r6_reload: assert property (@(posedge clk) disable iff (rst)
    (ovf && !cnt_we) |=> cnt_q == $past(rld_q));
  // R7: an interrupt pulse coincides with the reloaded count
  a_r7_irq_reload: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !$past(cnt_we)) |-> cnt_q == rld_q);
  // R11: disabled channel holds
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q[CTL_EN] && !cnt_we) |=> $stable(cnt_q));
  // R12: write wins over counting
  a_r12_write_wins: assert property (@(posedge clk) disable iff (rst)
    cnt_we |=> cnt_q == $past(wdata));
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import tmr_pkg::*;
#(
  parameter int N_TMR   = 4,
  parameter int CNT_W   = 16,
  parameter int N_PULSE = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           we,
  input  logic [$clog2(N_TMR):0]         addr,
  input  logic [CNT_W-1:0]               wdata,
  output logic [CNT_W-1:0]               rdata,
  output logic [N_TMR-1:0]               irq,
  output logic [N_PULSE-1:0]             ovf_pulse
);
  localparam int IDX_W = $clog2(N_TMR);

  logic [IDX_W-1:0] sel;
  logic             is_ctl;
  logic [CNT_W-1:0] cnt_a [N_TMR];
  logic [CNT_W-1:0] ctl_a [N_TMR];
  logic [N_TMR-1:0] step, ovf, tick, run;

  assign sel    = addr[IDX_W:1];
  assign is_ctl = addr[0];

  for (genvar i = 0; i < N_TMR; i++) begin : g_ch
    logic en, casc, cnt_we, ctl_we;
    assign en     = ctl_a[i][CTL_EN];
    assign casc   = ctl_a[i][CTL_CASC];
    assign cnt_we = we && !is_ctl && (sel == IDX_W'(i));
    assign ctl_we = we &&  is_ctl && (sel == IDX_W'(i));
    assign run[i] = en && !casc;

    tmr_prescale u_pre (
      .clk  (clk),
      .rst  (rst),
      .run  (run[i]),
      .code (ctl_a[i][1:0]),
      .tick (tick[i])
    );

    if (i == 0) begin : g_first
      assign step[i] = run[i] && tick[i];
      // R10: channel 0 in chained mode never counts
      a_r10_first_frozen: assert property (@(posedge clk) disable iff (rst)
        (casc && !cnt_we) |=> $stable(cnt_a[i]));
    end else begin : g_chain
      assign step[i] = en && (casc ? ovf[i-1] : tick[i]);
      // R9: chained channel holds unless the lower channel overflows
      a_r9_chain_idle: assert property (@(posedge clk) disable iff (rst)
        (en && casc && !ovf[i-1] && !cnt_we) |=> $stable(cnt_a[i]));
    end

    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .cnt_we (cnt_we),
      .ctl_we (ctl_we),
      .wdata  (wdata),
      .step   (step[i]),
      .cnt    (cnt_a[i]),
      .ctl    (ctl_a[i]),
      .ovf    (ovf[i]),
      .irq    (irq[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata     <= '0;
      ovf_pulse <= '0;
    end else begin
      if (int'(sel) < N_TMR) rdata <= is_ctl ? ctl_a[sel] : cnt_a[sel];
      else rdata <= '0;
      ovf_pulse <= ovf[N_PULSE-1:0];
    end
  end

  // R8: a pulse follows an overflow of its channel
  a_r8_pulse_src: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse[0] |-> $past(step[0]));
endmodule

// File: tb/tmr_bank_tb.sv
`timescale 1ns/1ps
module tmr_bank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0]  irq;
  logic [1:0]  ovf_pulse;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string tag = "R1";

  // reference state
  logic [15:0] m_cnt [4];
  logic [15:0] m_rld [4];
  logic [15:0] m_ctl [4];
  int          m_acc [4];
  logic [15:0] e_rd;
  logic [3:0]  e_irq;
  logic [1:0]  e_ovf;

  always #2.5 clk = ~clk;

  tmr_bank u_dut (
    .clk(clk), .rst(rst), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .ovf_pulse(ovf_pulse)
  );

  function automatic logic [2:0] ad(input int ch, input bit c);
    return {2'(ch), c};
  endfunction

  task automatic chk(input string t, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", t, got, exp, $time);
    end
  endtask

  task automatic compare();
    chk({tag, " rdata"}, rdata, e_rd);
    chk("R7 irq", {12'b0, irq}, {12'b0, e_irq});
    chk("R8 ovf_pulse", {14'b0, ovf_pulse}, {14'b0, e_ovf});
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_cnt[i] = 0; m_rld[i] = 0; m_ctl[i] = 0; m_acc[i] = 0;
    end
    e_rd = 0; e_irq = 0; e_ovf = 0;
  endtask

  task automatic model_step(input logic w, input logic [2:0] a, input logic [15:0] d);
    bit inc [4];
    bit ov [4];
    int div;
    for (int i = 0; i < 4; i++) begin
      bit en, cs;
      en = m_ctl[i][7]; cs = m_ctl[i][2];
      case (m_ctl[i][1:0])
        2'd0: div = 1;
        2'd1: div = 64;
        2'd2: div = 256;
        default: div = 1024;
      endcase
      inc[i] = 0;
      if (en && !cs) inc[i] = ((m_acc[i] % div) == div - 1);
      else if (en && cs && i > 0) inc[i] = ov[i-1];
      ov[i] = inc[i] && (m_cnt[i] == 16'hFFFF);
    end
    e_rd = a[0] ? m_ctl[a[2:1]] : m_cnt[a[2:1]];
    for (int i = 0; i < 4; i++) e_irq[i] = ov[i] && m_ctl[i][6];
    e_ovf = {ov[1], ov[0]};
    for (int i = 0; i < 4; i++) begin
      if (m_ctl[i][7] && !m_ctl[i][2]) m_acc[i] = (m_acc[i] + 1) % 1024;
      if (w && a[2:1] == 2'(i) && !a[0]) begin
        m_cnt[i] = d; m_rld[i] = d;
      end else if (ov[i]) m_cnt[i] = m_rld[i];
      else if (inc[i]) m_cnt[i] = m_cnt[i] + 16'd1;
      if (w && a[2:1] == 2'(i) && a[0]) m_ctl[i] = d;
    end
  endtask

  task automatic cyc(input logic w, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    compare();
    we = w; addr = a; wdata = d;
    model_step(w, a, d);
  endtask

  task automatic wr(input int ch, input bit c, input logic [15:0] d);
    cyc(1'b1, ad(ch, c), d);
  endtask

  task automatic idle(input int n, input logic [2:0] a);
    for (int k = 0; k < n; k++) cyc(1'b0, a, 16'h0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("R1 rdata in reset", rdata, 16'h0);
    chk("R1 irq in reset", {12'b0, irq}, 16'h0);
    chk("R1 ovf in reset", {14'b0, ovf_pulse}, 16'h0);
    model_reset();
    rst = 1'b0;
    model_step(1'b0, 3'd0, 16'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: read every register after reset
    tag = "R1";
    for (int i = 0; i < 8; i++) cyc(1'b0, 3'(i), 16'h0);

    // R2: counter write and readback
    tag = "R2";
    wr(0, 0, 16'h1234);
    idle(2, ad(0, 0));
    chk("R2 direct", rdata, 16'h1234);

    // R3: control word stored whole (no enable)
    tag = "R3";
    wr(3, 1, 16'h5A02);
    idle(2, ad(3, 1));
    chk("R3 direct", rdata, 16'h5A02);
    wr(3, 1, 16'h0000);

    // R6/R7: divide-by-1 overflow with interrupt
    tag = "R6";
    wr(0, 0, 16'hFFF0);
    wr(0, 1, 16'h00C0);
    idle(40, ad(0, 0));
    wr(0, 1, 16'h0080); // R8: overflow without interrupt enable
    tag = "R8";
    idle(40, ad(0, 0));
    wr(0, 1, 16'h0000);

    // R4: each prescale code on channel 1
    tag = "R4";
    wr(1, 0, 16'hFFFC);
    wr(1, 1, 16'h00C1);
    idle(300, ad(1, 0));
    wr(1, 1, 16'h00C2);
    idle(1100, ad(1, 0));
    wr(1, 1, 16'h00C3);
    idle(4200, ad(1, 0));
    wr(1, 1, 16'h0000);

    // R5: residue kept across disable and code change
    tag = "R5";
    wr(2, 0, 16'h0000);
    wr(2, 1, 16'h0083);
    idle(700, ad(2, 0));
    wr(2, 1, 16'h0003);
    idle(50, ad(2, 0));
    wr(2, 1, 16'h0082);
    idle(400, ad(2, 0));
    wr(2, 1, 16'h0001);

    // R11: disabled channel holds
    tag = "R11";
    wr(2, 0, 16'h7777);
    idle(30, ad(2, 0));
    chk("R11 direct", rdata, 16'h7777);

    // R10: channel 0 chained never counts
    tag = "R10";
    wr(0, 0, 16'h4321);
    wr(0, 1, 16'h0084);
    idle(50, ad(0, 0));
    chk("R10 direct", rdata, 16'h4321);
    wr(0, 1, 16'h0000);

    // R9: one overflow ripples through all chained channels
    tag = "R9";
    wr(1, 0, 16'hFFFF);
    wr(2, 0, 16'hFFFF);
    wr(3, 0, 16'h0005);
    wr(1, 1, 16'h00C4);
    wr(2, 1, 16'h00C4);
    wr(3, 1, 16'h0084);
    wr(0, 0, 16'hFFFF);
    wr(0, 1, 16'h0080);
    wr(0, 1, 16'h0000);
    idle(3, ad(3, 0));
    chk("R9 direct ch3", rdata, 16'h0006);
    for (int i = 0; i < 4; i++) wr(i, 1, 16'h0000);

    // R12: write while counting at divide-by-1
    tag = "R12";
    wr(0, 0, 16'hFFFD);
    wr(0, 1, 16'h00C0);
    cyc(1'b0, ad(0, 0), 16'h0);
    wr(0, 0, 16'h0100);
    wr(0, 0, 16'hFFFF);
    wr(0, 0, 16'h2000);
    idle(3, ad(0, 0));
    wr(0, 1, 16'h0000);

    // random register traffic across all modes
    tag = "R9";
    for (int k = 0; k < 6000; k++) begin
      logic [2:0]  a;
      logic [15:0] d;
      a = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 7) == 0) begin
        if (a[0]) d = 16'($urandom) & 16'hFFC7 | (($urandom_range(0, 2) == 0) ? 16'h0 : 16'h0080);
        else d = 16'hFFF0 | 16'($urandom_range(0, 15));
        cyc(1'b1, a, d);
      end else begin
        cyc(1'b0, a, 16'h0);
      end
    end

    idle(2, 3'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule